// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This unit sits between a 64-bit integer datapath and a byte-addressed data memory port. For each request it forms an effective address from a base value and a signed 16-bit offset. It checks whether the access is naturally aligned for its size. For stores it drives byte enables and steers the data into the correct lanes. For loads it picks the addressed bytes out of the returned quadword and extends them to 64 bits.

The memory strobes, address, enables and write data are combinational in the request cycle. The read data is expected back in that same cycle. The value written back to the register file, its valid strobe and the alignment fault flag are registered and appear one cycle later.

A single reservation flag links reserved loads to conditional stores. A reserved load sets the flag and records which quadword it read. A conditional store writes memory only while the flag is set. An ordinary store that lands in the reserved quadword drops the reservation.

Top module: `lsfmt_unit`

## Requirements
- R1: `req_op` encodings are: 0 address-only, 1 high address, 2 signed byte load, 3 unsigned byte load, 4 signed 16-bit load, 5 unsigned 16-bit load, 6 signed 32-bit load, 7 64-bit load, 8 reserved 32-bit load, 9 reserved 64-bit load, 10 quadword-window load, 11 immediate 32-bit, 12 byte store, 13 16-bit store, 14 32-bit store, 15 64-bit store, 16 conditional 32-bit store, 17 conditional 64-bit store, 18 quadword-window store. The effective address is `base_i` plus the sign-extended `offset_i`, a 64-bit sum that wraps. Op 0 writes this address back.
- R2: Op 1 adds the sign-extended offset multiplied by 65536 to the base and writes that sum back.
- R3: Loads take the bytes starting at lane `mem_addr_o[2:0]` of `mem_rdata_i`. Signed loads copy the top bit of the loaded field through bit 63. Unsigned loads fill the upper bits with zeros.
- R4: Op 11 writes back `store_i[31:0]` with bit 31 copied into bits 63:32.
- R5: An alignment fault is raised in these cases:
  - a 32-bit access whose address is not a multiple of 4;
  - a 64-bit access whose address is not a multiple of 8;
  - a 16-bit access at an odd address, when `WORD_ALIGN_CHK` is 1.

  A faulting access drives no memory strobe and no write-back, and leaves the reservation unchanged. `fault_o` is set in the following cycle.
- R6: Ops 10 and 18 use the effective address with bits 2:0 cleared. They never fault, and the store form enables all eight lanes.
- R7: Store enables are the size mask (1, 3, 0xF or 0xFF) shifted left by address bits 2:0. The store value is repeated across the write bus at its own width.
- R8: A non-faulting reserved load (op 8 or 9) sets the reservation and records the quadword it read, in addition to the normal load.
- R9: A conditional store writes memory only while the reservation is set. It writes back the old flag in bit 0 with all other bits zero, and then clears the flag.
- R10: An ordinary store that writes into the reserved quadword clears the reservation. A store to any other quadword leaves it set.
- R11: Reset clears the reservation, `wb_valid_o` and `fault_o`. With `req_valid` low, no strobe, write-back or fault is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 5 | Operation code (R1) |
| base_i | input | 64 | Base register value |
| offset_i | input | 16 | Signed immediate offset |
| store_i | input | 64 | Store source value, or the immediate for op 11 |
| mem_rdata_i | input | 64 | Quadword returned by memory in the request cycle |
| mem_addr_o | output | 64 | Byte address to memory |
| mem_be_o | output | 8 | Byte-lane enables for writes |
| mem_wdata_o | output | 64 | Lane-steered write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| wb_valid_o | output | 1 | Register write-back valid (registered) |
| wb_data_o | output | 64 | Register write-back value (registered) |
| fault_o | output | 1 | Alignment fault of previous request (registered) |

## Verification
The bench builds the unit with `WORD_ALIGN_CHK` at its default of 1. This makes odd-address 16-bit loads fault, alongside the 32-bit and 64-bit misalignment cases. Sign and zero extension are driven with lanes whose top bit is set, at several offsets inside the quadword. The reservation is walked through these sequences:
- set, then consumed by a conditional store;
- set, then survived by a store to a different quadword;
- set, then killed by a store into the reserved quadword;
- not set, because the reserved load faulted.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;
    localparam int XLEN  = 64;
    localparam int OFFW  = 16;
    localparam int HI_SH = 16;
    localparam int LANES = XLEN / 8;
    localparam int LSB   = $clog2(LANES);
    localparam int OPW   = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADDR     = 5'd0,
        OP_ADDR_HI  = 5'd1,
        OP_LD8S     = 5'd2,
        OP_LD8U     = 5'd3,
        OP_LD16S    = 5'd4,
        OP_LD16U    = 5'd5,
        OP_LD32S    = 5'd6,
        OP_LD64     = 5'd7,
        OP_LD32_RSV = 5'd8,
        OP_LD64_RSV = 5'd9,
        OP_LD64_WIN = 5'd10,
        OP_IMM32    = 5'd11,
        OP_ST8      = 5'd12,
        OP_ST16     = 5'd13,
        OP_ST32     = 5'd14,
        OP_ST64     = 5'd15,
        OP_ST32_CND = 5'd16,
        OP_ST64_CND = 5'd17,
        OP_ST64_WIN = 5'd18
    } op_e;

    typedef enum logic [1:0] {SZ8, SZ16, SZ32, SZ64} size_e;

    typedef struct packed {
        logic  is_ld;
        logic  is_st;
        logic  sgn;
        size_e sz;
        logic  win;
        logic  rsv;
        logic  cnd;
        logic  hi;
        logic  addr_only;
        logic  imm;
    } dec_t;

    function automatic dec_t decode(input logic [OPW-1:0] op);
        dec_t d;
        d = '0;
        d.sz = SZ64;
        case (op_e'(op))
            OP_ADDR:     d.addr_only = 1'b1;
            OP_ADDR_HI:  begin d.addr_only = 1'b1; d.hi = 1'b1; end
            OP_LD8S:     begin d.is_ld = 1'b1; d.sgn = 1'b1; d.sz = SZ8;  end
            OP_LD8U:     begin d.is_ld = 1'b1; d.sz = SZ8;  end
            OP_LD16S:    begin d.is_ld = 1'b1; d.sgn = 1'b1; d.sz = SZ16; end
            OP_LD16U:    begin d.is_ld = 1'b1; d.sz = SZ16; end
            OP_LD32S:    begin d.is_ld = 1'b1; d.sgn = 1'b1; d.sz = SZ32; end
            OP_LD64:     d.is_ld = 1'b1;
            OP_LD32_RSV: begin d.is_ld = 1'b1; d.sgn = 1'b1; d.sz = SZ32; d.rsv = 1'b1; end
            OP_LD64_RSV: begin d.is_ld = 1'b1; d.rsv = 1'b1; end
            OP_LD64_WIN: begin d.is_ld = 1'b1; d.win = 1'b1; end
            OP_IMM32:    d.imm = 1'b1;
            OP_ST8:      begin d.is_st = 1'b1; d.sz = SZ8;  end
            OP_ST16:     begin d.is_st = 1'b1; d.sz = SZ16; end
            OP_ST32:     begin d.is_st = 1'b1; d.sz = SZ32; end
            OP_ST64:     d.is_st = 1'b1;
            OP_ST32_CND: begin d.is_st = 1'b1; d.sz = SZ32; d.cnd = 1'b1; end
            OP_ST64_CND: begin d.is_st = 1'b1; d.cnd = 1'b1; end
            OP_ST64_WIN: begin d.is_st = 1'b1; d.win = 1'b1; end
            default:     d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/lsfmt_agen.sv
module lsfmt_agen
    import lsfmt_pkg::*;
#(
    parameter bit WORD_ALIGN_CHK = 1'b1
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [OFFW-1:0] off_i,
    input  logic            hi_i,
    input  logic            win_i,
    input  size_e           sz_i,
    output logic [XLEN-1:0] ea_o,
    output logic [XLEN-1:0] maddr_o,
    output logic            misalign_o
);
    logic [XLEN-1:0] off_sx;
    logic            odd16;

    assign off_sx  = {{(XLEN-OFFW){off_i[OFFW-1]}}, off_i};
    assign ea_o    = base_i + (hi_i ? (off_sx << HI_SH) : off_sx);
    assign maddr_o = win_i ? {ea_o[XLEN-1:LSB], {LSB{1'b0}}} : ea_o;

    generate
        if (WORD_ALIGN_CHK) begin : g_wchk
            assign odd16 = ea_o[0];
        end else begin : g_wnochk
            assign odd16 = 1'b0;
        end
    endgenerate

    always_comb begin
        misalign_o = 1'b0;
        if (!win_i) begin
            case (sz_i)
                SZ16:    misalign_o = odd16;
                SZ32:    misalign_o = |ea_o[1:0];
                SZ64:    misalign_o = |ea_o[LSB-1:0];
                default: misalign_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lsfmt_lane.sv
module lsfmt_lane
    import lsfmt_pkg::*;
(
    input  size_e           sz_i,
    input  logic [LSB-1:0]  lane_i,
    input  logic            sgn_i,
    input  logic [XLEN-1:0] sdata_i,
    input  logic [XLEN-1:0] rdata_i,
    output logic [LANES-1:0] be_o,
    output logic [XLEN-1:0] wdata_o,
    output logic [XLEN-1:0] ldata_o
);
    logic [LANES-1:0] mask;
    logic [XLEN-1:0]  shifted;

    always_comb begin
        case (sz_i)
            SZ8:     mask = LANES'(8'h01);
            SZ16:    mask = LANES'(8'h03);
            SZ32:    mask = LANES'(8'h0F);
            default: mask = '1;
        endcase
        be_o = mask << lane_i;
    end

    always_comb begin
        case (sz_i)
            SZ8:     wdata_o = {(XLEN/8){sdata_i[7:0]}};
            SZ16:    wdata_o = {(XLEN/16){sdata_i[15:0]}};
            SZ32:    wdata_o = {(XLEN/32){sdata_i[31:0]}};
            default: wdata_o = sdata_i;
        endcase
    end

    assign shifted = rdata_i >> {lane_i, 3'b000};

    always_comb begin
        case (sz_i)
            SZ8:     ldata_o = {{(XLEN-8){sgn_i & shifted[7]}}, shifted[7:0]};
            SZ16:    ldata_o = {{(XLEN-16){sgn_i & shifted[15]}}, shifted[15:0]};
            SZ32:    ldata_o = {{(XLEN-32){sgn_i & shifted[31]}}, shifted[31:0]};
            default: ldata_o = shifted;
        endcase
    end
endmodule

// File: rtl/lsfmt_resv.sv
module lsfmt_resv
    import lsfmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_i,
    input  logic                clr_i,
    input  logic                snoop_i,
    input  logic [XLEN-LSB-1:0] qw_i,
    output logic                held_o
);
    logic                held_q;
    logic [XLEN-LSB-1:0] qw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            qw_q   <= '0;
        end else if (set_i) begin
            held_q <= 1'b1;
            qw_q   <= qw_i;
        end else if (clr_i || (snoop_i && qw_i == qw_q)) begin
            held_q <= 1'b0;
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/lsfmt_unit.sv
module lsfmt_unit
    import lsfmt_pkg::*;
#(
    parameter bit WORD_ALIGN_CHK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OPW-1:0]   req_op,
    input  logic [XLEN-1:0]  base_i,
    input  logic [OFFW-1:0]  offset_i,
    input  logic [XLEN-1:0]  store_i,
    input  logic [XLEN-1:0]  mem_rdata_i,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [LANES-1:0] mem_be_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    output logic             mem_we_o,
    output logic             mem_re_o,
    output logic             wb_valid_o,
    output logic [XLEN-1:0]  wb_data_o,
    output logic             fault_o
);
    dec_t            dec;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] maddr;
    logic            misalign;
    logic            flt;
    logic            go;
    logic [XLEN-1:0] ldata;
    logic            held;
    logic            wb_v_d;
    logic [XLEN-1:0] wb_d;

    assign dec = decode(req_op);

    lsfmt_agen #(.WORD_ALIGN_CHK(WORD_ALIGN_CHK)) u_agen (
        .base_i     (base_i),
        .off_i      (offset_i),
        .hi_i       (dec.hi),
        .win_i      (dec.win),
        .sz_i       (dec.sz),
        .ea_o       (ea),
        .maddr_o    (maddr),
        .misalign_o (misalign)
    );

    lsfmt_lane u_lane (
        .sz_i    (dec.sz),
        .lane_i  (maddr[LSB-1:0]),
        .sgn_i   (dec.sgn),
        .sdata_i (store_i),
        .rdata_i (mem_rdata_i),
        .be_o    (mem_be_o),
        .wdata_o (mem_wdata_o),
        .ldata_o (ldata)
    );

    assign flt = req_valid && (dec.is_ld || dec.is_st) && misalign;
    assign go  = req_valid && !flt;

    lsfmt_resv u_resv (
        .clk     (clk),
        .rst     (rst),
        .set_i   (go && dec.rsv),
        .clr_i   (go && dec.cnd),
        .snoop_i (go && dec.is_st && !dec.cnd),
        .qw_i    (maddr[XLEN-1:LSB]),
        .held_o  (held)
    );

    assign mem_addr_o = maddr;
    assign mem_re_o   = go && dec.is_ld;
    assign mem_we_o   = go && dec.is_st && (!dec.cnd || held);

    always_comb begin
        wb_v_d = go && (dec.is_ld || dec.addr_only || dec.imm || dec.cnd);
        if (dec.addr_only)
            wb_d = ea;
        else if (dec.imm)
            wb_d = {{(XLEN-32){store_i[31]}}, store_i[31:0]};
        else if (dec.cnd)
            wb_d = {{(XLEN-1){1'b0}}, held};
        else
            wb_d = ldata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid_o <= 1'b0;
            wb_data_o  <= '0;
            fault_o    <= 1'b0;
        end else begin
            wb_valid_o <= wb_v_d;
            wb_data_o  <= wb_d;
            fault_o    <= flt;
        end
    end
endmodule

// File: rtl/lsfmt_unit_chk.sv
module lsfmt_unit_chk
    import lsfmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [OPW-1:0]   req_op,
    input logic [XLEN-1:0]  mem_addr_o,
    input logic [LANES-1:0] mem_be_o,
    input logic             mem_we_o,
    input logic             mem_re_o,
    input logic             wb_valid_o,
    input logic [XLEN-1:0]  wb_data_o,
    input logic             fault_o
);
    AST_ST32_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && req_op == OP_ST32) |-> (mem_addr_o[1:0] == 2'b00)); // R5

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !wb_valid_o); // R5

    AST_WIN_FULL_LANES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_ST64_WIN) |->
        (mem_we_o && mem_be_o == '1 && mem_addr_o[LSB-1:0] == '0)); // R6

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && req_op == OP_ST8) |-> ($countones(mem_be_o) == 1)); // R7

    AST_CND_FLAG_BIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == OP_ST32_CND || req_op == OP_ST64_CND)) |=>
        (fault_o || (wb_valid_o && wb_data_o[XLEN-1:1] == '0))); // R9

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!mem_we_o && !mem_re_o)); // R11

    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!wb_valid_o && !fault_o)); // R11
endmodule

bind lsfmt_unit lsfmt_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .wb_valid_o (wb_valid_o),
    .wb_data_o  (wb_data_o),
    .fault_o    (fault_o)
);

// File: tb/lsfmt_unit_bench.sv
`timescale 1ns/1ps
module lsfmt_unit_bench;
    import lsfmt_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [OPW-1:0]   req_op = '0;
    logic [XLEN-1:0]  base_i = '0;
    logic [OFFW-1:0]  offset_i = '0;
    logic [XLEN-1:0]  store_i = '0;
    logic [XLEN-1:0]  mem_rdata_i = '0;
    logic [XLEN-1:0]  mem_addr_o;
    logic [LANES-1:0] mem_be_o;
    logic [XLEN-1:0]  mem_wdata_o;
    logic             mem_we_o;
    logic             mem_re_o;
    logic             wb_valid_o;
    logic [XLEN-1:0]  wb_data_o;
    logic             fault_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic            v;
        logic [XLEN-1:0] d;
        logic            f;
        string           tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    lsfmt_unit u_lsfmt_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .base_i(base_i), .offset_i(offset_i), .store_i(store_i),
        .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o), .fault_o(fault_o)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input op_e op, input logic [XLEN-1:0] b, input logic [OFFW-1:0] o,
                         input logic [XLEN-1:0] sd, input logic [XLEN-1:0] rd,
                         input logic [XLEN-1:0] e_addr, input logic e_re, input logic e_we,
                         input logic [LANES-1:0] e_be, input logic [XLEN-1:0] e_wd,
                         input logic e_v, input logic [XLEN-1:0] e_d, input logic e_f,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base_i = b; offset_i = o;
        store_i = sd; mem_rdata_i = rd;
        #1;
        chk(mem_addr_o == e_addr, tag, "addr", mem_addr_o, e_addr);
        chk(mem_re_o == e_re, tag, "re", XLEN'(mem_re_o), XLEN'(e_re));
        chk(mem_we_o == e_we, tag, "we", XLEN'(mem_we_o), XLEN'(e_we));
        if (e_we) begin
            chk(mem_be_o == e_be, tag, "be", XLEN'(mem_be_o), XLEN'(e_be));
            chk(mem_wdata_o == e_wd, tag, "wdata", mem_wdata_o, e_wd);
        end
        e.v = e_v; e.d = e_d; e.f = e_f; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(wb_valid_o == e.v, e.tag, "wb_valid", XLEN'(wb_valid_o), XLEN'(e.v));
            chk(fault_o == e.f, e.tag, "fault", XLEN'(fault_o), XLEN'(e.f));
            if (e.v) chk(wb_data_o == e.d, e.tag, "wb_data", wb_data_o, e.d);
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wb_valid_o && !fault_o, "R11", "reset", {wb_valid_o, fault_o}, 0);

        // R1 address-only with negative offset and with wrap
        issue(OP_ADDR, 64'h1000, 16'hFFF0, 0, 0, 64'h0FF0, 0, 0, 0, 0, 1, 64'h0FF0, 0, "R1");
        issue(OP_ADDR, '1, 16'h0002, 0, 0, 64'h1, 0, 0, 0, 0, 1, 64'h1, 0, "R1");
        // R2 high form, most negative offset
        issue(OP_ADDR_HI, 64'h10, 16'h8000, 0, 0, 64'hFFFF_FFFF_8000_0010, 0, 0, 0, 0,
              1, 64'hFFFF_FFFF_8000_0010, 0, "R2");
        // R3 extension
        issue(OP_LD8S, 64'h2000, 16'h3, 0, 64'h0000_0000_8000_0000, 64'h2003, 1, 0, 0, 0,
              1, 64'hFFFF_FFFF_FFFF_FF80, 0, "R3");
        issue(OP_LD8U, 64'h2000, 16'h3, 0, 64'h0000_0000_8000_0000, 64'h2003, 1, 0, 0, 0,
              1, 64'h80, 0, "R3");
        issue(OP_LD16S, 64'h2000, 16'h6, 0, 64'hBEEF_0000_0000_0000, 64'h2006, 1, 0, 0, 0,
              1, 64'hFFFF_FFFF_FFFF_BEEF, 0, "R3");
        issue(OP_LD16U, 64'h2000, 16'h6, 0, 64'hBEEF_0000_0000_0000, 64'h2006, 1, 0, 0, 0,
              1, 64'hBEEF, 0, "R3");
        issue(OP_LD32S, 64'h2000, 16'h4, 0, 64'h7654_3210_0000_0000, 64'h2004, 1, 0, 0, 0,
              1, 64'h7654_3210, 0, "R3");
        issue(OP_LD64, 64'h2000, 16'h0, 0, 64'h0123_4567_89AB_CDEF, 64'h2000, 1, 0, 0, 0,
              1, 64'h0123_4567_89AB_CDEF, 0, "R3");
        // R5 alignment faults
        issue(OP_LD32S, 64'h2000, 16'h2, 0, 0, 64'h2002, 0, 0, 0, 0, 0, 0, 1, "R5");
        issue(OP_LD64, 64'h2000, 16'h4, 0, 0, 64'h2004, 0, 0, 0, 0, 0, 0, 1, "R5");
        issue(OP_LD16S, 64'h2000, 16'h1, 0, 0, 64'h2001, 0, 0, 0, 0, 0, 0, 1, "R5");
        issue(OP_ST32, 64'h2000, 16'h6, 64'h55, 0, 64'h2006, 0, 0, 0, 0, 0, 0, 1, "R5");
        // R6 quadword window
        issue(OP_LD64_WIN, 64'h2000, 16'h000D, 0, 64'hAAAA_5555_1234_0F0F, 64'h2008, 1, 0, 0, 0,
              1, 64'hAAAA_5555_1234_0F0F, 0, "R6");
        issue(OP_ST64_WIN, 64'h2000, 16'h000B, 64'hDEAD_BEEF_0BAD_F00D, 0, 64'h2008, 0, 1, 8'hFF,
              64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0, "R6");
        // R4 immediate
        issue(OP_IMM32, 0, 0, 64'h1234_5678_8000_0001, 0, 64'h0, 0, 0, 0, 0,
              1, 64'hFFFF_FFFF_8000_0001, 0, "R4");
        // R7 store lanes
        issue(OP_ST8, 64'h3000, 16'h5, 64'h1122_3344_5566_77AB, 0, 64'h3005, 0, 1, 8'h20,
              64'hABAB_ABAB_ABAB_ABAB, 0, 0, 0, "R7");
        issue(OP_ST16, 64'h3000, 16'h2, 64'h0000_0000_0000_CDEF, 0, 64'h3002, 0, 1, 8'h0C,
              64'hCDEF_CDEF_CDEF_CDEF, 0, 0, 0, "R7");
        issue(OP_ST32, 64'h3000, 16'h4, 64'hFFFF_0000_89AB_CDEF, 0, 64'h3004, 0, 1, 8'hF0,
              64'h89AB_CDEF_89AB_CDEF, 0, 0, 0, "R7");
        issue(OP_ST64, 64'h3000, 16'h0, 64'h0F1E_2D3C_4B5A_6978, 0, 64'h3000, 0, 1, 8'hFF,
              64'h0F1E_2D3C_4B5A_6978, 0, 0, 0, "R7");
        // R9 conditional store without reservation
        issue(OP_ST32_CND, 64'h4000, 16'h0, 64'h77, 0, 64'h4000, 0, 0, 0, 0, 1, 64'h0, 0, "R9");
        // R8 reserved load, then R9 success, then failure
        issue(OP_LD64_RSV, 64'h4000, 16'h8, 0, 64'h0000_1111_2222_3333, 64'h4008, 1, 0, 0, 0,
              1, 64'h0000_1111_2222_3333, 0, "R8");
        issue(OP_ST64_CND, 64'h4000, 16'h8, 64'hCAFE, 0, 64'h4008, 0, 1, 8'hFF, 64'hCAFE,
              1, 64'h1, 0, "R9");
        issue(OP_ST64_CND, 64'h4000, 16'h8, 64'hCAFE, 0, 64'h4008, 0, 0, 0, 0, 1, 64'h0, 0, "R9");
        // R10 store to other quadword keeps reservation
        issue(OP_LD32_RSV, 64'h4000, 16'h10, 0, 64'hFFFF_FFFF_8000_0000, 64'h4010, 1, 0, 0, 0,
              1, 64'hFFFF_FFFF_8000_0000, 0, "R8");
        issue(OP_ST8, 64'h4000, 16'h20, 64'h5A, 0, 64'h4020, 0, 1, 8'h01,
              64'h5A5A_5A5A_5A5A_5A5A, 0, 0, 0, "R10");
        issue(OP_ST32_CND, 64'h4000, 16'h10, 64'h1234_5678, 0, 64'h4010, 0, 1, 8'h0F,
              64'h1234_5678_1234_5678, 1, 64'h1, 0, "R10");
        // R10 store into reserved quadword kills it
        issue(OP_LD64_RSV, 64'h4000, 16'h18, 0, 64'h9, 64'h4018, 1, 0, 0, 0, 1, 64'h9, 0, "R8");
        issue(OP_ST16, 64'h4000, 16'h1E, 64'hABCD, 0, 64'h401E, 0, 1, 8'hC0,
              64'hABCD_ABCD_ABCD_ABCD, 0, 0, 0, "R10");
        issue(OP_ST64_CND, 64'h4000, 16'h18, 64'h1, 0, 64'h4018, 0, 0, 0, 0, 1, 64'h0, 0, "R10");
        // R5 faulting reserved load leaves reservation clear
        issue(OP_LD64_RSV, 64'h4000, 16'h4, 0, 64'h3, 64'h4004, 0, 0, 0, 0, 0, 0, 1, "R5");
        issue(OP_ST64_CND, 64'h4000, 16'h0, 64'h1, 0, 64'h4000, 0, 0, 0, 0, 1, 64'h0, 0, "R5");

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(!mem_we_o && !mem_re_o, "R11", "idle strobes", {mem_we_o, mem_re_o}, 0);
        repeat (2) @(negedge clk);
        #1;
        chk(!wb_valid_o && !fault_o, "R11", "idle wb", {wb_valid_o, fault_o}, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule